// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory Access Controller

This block connects a simple CPU register bus to a 512-byte nonvolatile byte array. Software sees four byte registers. Two of them form the access address. One is a shared data register. The last is a control/status register. Software starts a read or a write by setting a strobe bit in the control register. The block then asserts a CPU stall output for a fixed number of cycles: four after a read and two after a write.

Writes are protected and self-timed. A write strobe is accepted only within four cycles after an arming bit has been set. Once accepted, the write captures its own copies of the address and the data. It then holds a busy flag for a parameterised number of cycles, which stands in for the slow programming time. The byte is committed to the array when that count runs out. Software polls the busy flag before it starts the next write. While the flag is set, any read or write strobe is ignored.

Register map, selected by `io_addr`:
- 0: address bits 7:0.
- 1: address bit 8, held in bit 0.
- 2: data register.
- 3: control/status register. Bit 0 is the read strobe, bit 1 the write strobe, bit 2 the arm bit, and bit 3 the busy flag, which is read-only.

Top module: `nvm_access_ctrl`

## Requirements
- R1: The array holds 512 bytes at linear addresses 0 to 511. A completed write followed by a read of the same address returns the byte written, including at addresses 0, 255, 256 and 511.
- R2: Register 0 holds address bits 7:0, and bit 0 of register 1 holds address bit 8. When register 1 is read, bits 7:1 are always 0, whatever was written to them.
- R3: Register 2 supplies the byte for a write. An accepted read loads register 2 with the addressed byte.
- R4: A read strobe (bit 0 of register 3) that is accepted holds `cpu_stall` high for exactly 4 cycles, starting the cycle after the strobe is captured.
- R5: An accepted write strobe (bit 1 of register 3) holds `cpu_stall` high for exactly 2 cycles.
- R6: After an accepted write, the busy flag (bit 3 of register 3) reads 1 for exactly WR_CYCLES cycles. The array is updated when the flag clears.
- R7: Writing 1 to bit 2 of register 3 arms writes for 4 cycles. The arm state reads back in bit 2 and clears by itself afterwards. A write strobe is accepted only if it is captured 1 to 4 cycles after the arming edge. A write strobe that is not armed causes no busy flag, no stall and no array change.
- R8: A read strobe that arrives while busy is ignored. Register 2 keeps its value and `cpu_stall` stays low.
- R9: A write in progress uses the address and data captured at its strobe. Writes to registers 0 to 2 while busy do not change what is committed.
- R10: A write strobe that arrives while busy, even when armed, is ignored. It neither extends the busy interval nor writes the array.
- R11: After reset, `cpu_stall` is 0, register 3 reads 0, and register 2 reads 0. The address registers have no reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 2 | Register select |
| io_we | input | 1 | Register write enable |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Register read data for the selected register (combinational) |
| cpu_stall | output | 1 | Holds the CPU after an access |

## Verification
The assertions assume that the CPU issues no register writes while `cpu_stall` is high, as a stalled core would. They also assume it does not re-arm while writes are already armed. The stall-length and arm-window checks count consecutive cycles, so a second access stacked on an active stall would break them. The bench's stimulus waits for the stall to end before each new bus write. It arms exactly once per write attempt, and it loads the address registers before every access.

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl #(
  parameter int ADDR_W    = 9,
  parameter int WR_CYCLES = 16000,
  parameter int RD_STALL  = 4,
  parameter int WR_STALL  = 2,
  parameter int ARM_WIN   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] io_addr,
  input  logic       io_we,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       cpu_stall
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int HI_W      = ADDR_W - 8;
  localparam int STALL_MAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int WC_W      = $clog2(WR_CYCLES + 1);
  localparam int SC_W      = $clog2(STALL_MAX + 1);
  localparam int AC_W      = $clog2(ARM_WIN + 1);

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] addr_q, lat_addr;
  logic [7:0]        data_q, lat_data;
  logic [WC_W-1:0]   busy_cnt;
  logic [SC_W-1:0]   stall_cnt;
  logic [AC_W-1:0]   arm_cnt;

  wire ctrl_wr = io_we && (io_addr == 2'd3);
  wire busy    = (busy_cnt != '0);
  wire armed   = (arm_cnt != '0);
  wire wr_go   = ctrl_wr && io_wdata[1] && armed && !busy;
  wire rd_go   = ctrl_wr && io_wdata[0] && !busy && !wr_go;

  assign cpu_stall = (stall_cnt != '0);

  always_ff @(posedge clk) begin
    if (io_we && io_addr == 2'd0) addr_q[7:0] <= io_wdata;
    if (io_we && io_addr == 2'd1) addr_q[ADDR_W-1:8] <= io_wdata[HI_W-1:0];
    if (wr_go) begin
      lat_addr <= addr_q;
      lat_data <= data_q;
    end
    if (busy_cnt == WC_W'(1)) mem[lat_addr] <= lat_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      busy_cnt  <= '0;
      stall_cnt <= '0;
      arm_cnt   <= '0;
    end else begin
      if (io_we && io_addr == 2'd2) data_q <= io_wdata;
      else if (rd_go)               data_q <= mem[addr_q];

      if (wr_go)     busy_cnt <= WC_W'(WR_CYCLES);
      else if (busy) busy_cnt <= busy_cnt - 1'b1;

      if (wr_go)          stall_cnt <= SC_W'(WR_STALL);
      else if (rd_go)     stall_cnt <= SC_W'(RD_STALL);
      else if (cpu_stall) stall_cnt <= stall_cnt - 1'b1;

      if (wr_go)                        arm_cnt <= '0;
      else if (ctrl_wr && io_wdata[2])  arm_cnt <= AC_W'(ARM_WIN);
      else if (armed)                   arm_cnt <= arm_cnt - 1'b1;
    end
  end

  always_comb begin
    case (io_addr)
      2'd0:    io_rdata = addr_q[7:0];
      2'd1:    io_rdata = 8'(addr_q[ADDR_W-1:8]);
      2'd2:    io_rdata = data_q;
      default: io_rdata = {4'b0, busy, armed, 2'b0};
    endcase
  end
endmodule

// File: rtl/nvm_access_chk.sv
module nvm_access_chk #(
  parameter int ADDR_W    = 9,
  parameter int WR_CYCLES = 16000,
  parameter int RD_STALL  = 4,
  parameter int WR_STALL  = 2,
  parameter int ARM_WIN   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        io_addr,
  input logic              io_we,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              cpu_stall,
  input logic              busy,
  input logic              armed,
  input logic [7:0]        data_q,
  input logic [ADDR_W-1:0] lat_addr,
  input logic [7:0]        lat_data
);
  localparam int HI_W = ADDR_W - 8;

  int stall_run, busy_run, arm_run;
  wire ctrl_wr = io_we && (io_addr == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_run <= 0;
      busy_run  <= 0;
      arm_run   <= 0;
    end else begin
      stall_run <= cpu_stall ? stall_run + 1 : 0;
      busy_run  <= busy ? busy_run + 1 : 0;
      if (ctrl_wr && io_wdata[2]) arm_run <= 0;
      else if (armed)             arm_run <= arm_run + 1;
      else                        arm_run <= 0;
    end
  end

  a_r2_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == 2'd1) |-> (io_rdata[7:HI_W] == '0));

  a_r4_read_stall_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && io_wdata[0] && !io_wdata[1] && !busy) |=> cpu_stall);

  a_r5_stall_len: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_run != 0 && !cpu_stall) |-> (stall_run == RD_STALL || stall_run == WR_STALL));

  a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_run != 0 && !busy) |-> (busy_run == WR_CYCLES));

  a_r7_arm_window: assert property (@(posedge clk) disable iff (!rst_n)
    arm_run <= ARM_WIN);

  a_r7_unarmed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && io_wdata[1] && !io_wdata[0] && !armed && !busy) |=> !busy);

  a_r8_busy_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && io_wdata[0] && busy) |=> $stable(data_q));

  a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(lat_addr) && $stable(lat_data)));
endmodule

bind nvm_access_ctrl nvm_access_chk #(
  .ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES), .RD_STALL(RD_STALL),
  .WR_STALL(WR_STALL), .ARM_WIN(ARM_WIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_stall(cpu_stall),
  .busy(busy), .armed(armed), .data_q(data_q),
  .lat_addr(lat_addr), .lat_data(lat_data)
);

// File: tb/nvm_access_ctrl_bench.sv
module nvm_access_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WR_CYC     = 24;
  localparam logic [16:0] VEC [8] = '{
    {9'd0,   8'h5A}, {9'd511, 8'hA5}, {9'd256, 8'h3C}, {9'd255, 8'hC3},
    {9'd1,   8'h01}, {9'd510, 8'hFE}, {9'd128, 8'h80}, {9'd300, 8'h77}
  };

  logic       clk = 0, rst_n = 0, io_we = 0;
  logic [1:0] io_addr = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic       cpu_stall;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  nvm_access_ctrl #(.WR_CYCLES(WR_CYC)) u_nvm_access_ctrl (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_stall(cpu_stall));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_we = 1;
    @(negedge clk);
    io_we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    io_we = 0; io_addr = a; #1; d = io_rdata;
  endtask

  task automatic set_addr(input logic [8:0] a);
    bus_wr(2'd0, a[7:0]);
    bus_wr(2'd1, {7'b0, a[8]});
  endtask

  task automatic wait_idle(output int st, output int bz);
    logic [7:0] r;
    st = 0; bz = 0;
    bus_rd(2'd3, r);
    while (r[3] || cpu_stall) begin
      if (cpu_stall) st++;
      if (r[3]) bz++;
      @(negedge clk);
      bus_rd(2'd3, r);
    end
  endtask

  task automatic do_write(input logic [8:0] a, input logic [7:0] d, output int st, output int bz);
    set_addr(a);
    bus_wr(2'd2, d);
    bus_wr(2'd3, 8'h04);
    bus_wr(2'd3, 8'h02);
    wait_idle(st, bz);
  endtask

  task automatic do_read(input logic [8:0] a, output logic [7:0] d, output int st);
    int bz;
    set_addr(a);
    bus_wr(2'd3, 8'h01);
    wait_idle(st, bz);
    bus_rd(2'd2, d);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int st, bz;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    bus_rd(2'd3, r); check("R11 ctrl after reset", r, 0);
    bus_rd(2'd2, r); check("R11 data after reset", r, 0);
    check("R11 stall after reset", cpu_stall, 0);

    set_addr(9'h1FF);
    bus_wr(2'd1, 8'hFF);
    bus_rd(2'd1, r); check("R2 high byte masked", r, 8'h01);
    bus_rd(2'd0, r); check("R2 low byte", r, 8'hFF);

    foreach (VEC[i]) begin
      do_write(VEC[i][16:8], VEC[i][7:0], st, bz);
      check("R5 write stall", st, 2);
      check("R6 busy length", bz, WR_CYC);
    end
    foreach (VEC[i]) begin
      do_read(VEC[i][16:8], r, st);
      check("R1 R3 readback", r, VEC[i][7:0]);
      check("R4 read stall", st, 4);
    end

    set_addr(9'd0);
    bus_wr(2'd2, 8'h11);
    bus_wr(2'd3, 8'h02);
    bus_rd(2'd3, r); check("R7 unarmed no busy", r, 0);
    check("R7 unarmed no stall", cpu_stall, 0);
    do_read(9'd0, r, st); check("R7 unarmed no change", r, 8'h5A);

    bus_wr(2'd3, 8'h04);
    bus_rd(2'd3, r); check("R7 arm readback", r, 8'h04);
    repeat (3) @(negedge clk);
    bus_rd(2'd3, r); check("R7 arm still set", r, 8'h04);
    @(negedge clk);
    bus_rd(2'd3, r); check("R7 arm self-clear", r, 0);

    set_addr(9'd2);
    bus_wr(2'd2, 8'h22);
    bus_wr(2'd3, 8'h04);
    repeat (4) @(negedge clk);
    bus_wr(2'd3, 8'h02);
    bus_rd(2'd3, r); check("R7 late strobe rejected", r[3], 0);

    bus_wr(2'd3, 8'h04);
    repeat (3) @(negedge clk);
    bus_wr(2'd3, 8'h02);
    bus_rd(2'd3, r); check("R7 last-cycle strobe accepted", r[3], 1);
    wait_idle(st, bz);
    do_read(9'd2, r, st); check("R7 armed write landed", r, 8'h22);

    set_addr(9'd1);
    bus_wr(2'd2, 8'h99);
    bus_wr(2'd3, 8'h04);
    bus_wr(2'd3, 8'h02);
    @(negedge clk); @(negedge clk);
    set_addr(9'd0);
    bus_wr(2'd3, 8'h01);
    check("R8 no stall when busy", cpu_stall, 0);
    bus_rd(2'd2, r); check("R8 data kept", r, 8'h99);
    bus_wr(2'd2, 8'h42);
    bus_wr(2'd3, 8'h04);
    bus_wr(2'd3, 8'h02);
    check("R10 no stall when busy", cpu_stall, 0);
    wait_idle(st, bz);
    bus_rd(2'd3, r); check("R10 idle after write", r, 0);
    do_read(9'd1, r, st); check("R9 latched address and data", r, 8'h99);
    do_read(9'd0, r, st); check("R9 R10 other byte untouched", r, 8'h5A);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule